// File: doc/BRIEF.md
# Multiplexed Front-End Readout Sequencer

This block controls the readout of analogue front-end chips that sample every channel on a hold signal and then present their channels one after another on a serial output, advancing by one channel per multiplex clock. A rising edge on the trigger input starts a readout. After a programmable delay the sequencer drives the active-low hold line. If calibration is enabled it pulses a calibration strobe at the same time. It then produces a burst of multiplex clocks, with a start token placed so that the chips capture it on the second rising clock edge.

Each multiplex clock is followed by one conversion request to a bank of per-chip ADC lanes that share a common start. When the conversion completes, the sequencer writes one tagged word per chip into the output FIFO interface. The words of a slot go out in output-connector order, and a configurable map picks the chip that feeds each connector. The default burst is 38 clocks. Slot 0 and slot 37 carry baselines, slots 1 to 18 the gain-1 samples and slots 19 to 36 the quiescent levels. The clock count is a parameter, so a shorter 19-clock mode can be built. Hold is released and a done pulse is raised only after the last word of the burst has been written.

Top module: `fe_mux_readout`

## Requirements
- R1: After reset hold_no_o is 1, and mux_clk_o, srin_o, cal_o, adc_start_o, fifo_wr_o and done_o are 0. miss_cnt_o is 0, the loaded delay is 0, calibration is off and the map is the identity.
- R2: A 0-to-1 transition of trig_i while idle starts a readout. hold_no_o goes low D+1 rising edges after the edge that samples the transition, where D is the loaded delay. A trigger held high starts only one readout.
- R3: With calibration enabled, cal_o is high for exactly one cycle, the first cycle in which hold_no_o is low. With calibration disabled, cal_o stays low for the whole readout.
- R4: A readout produces exactly N_MCLK (38) mux_clk_o pulses, each one cycle high, all while hold_no_o is low.
- R5: srin_o is 1 at the second mux_clk_o rising edge of a readout and in the cycle before it. srin_o is 0 at every other rising edge.
- R6: Each mux_clk_o pulse is followed by exactly one single-cycle adc_start_o, never coincident with mux_clk_o. The lane samples are taken from adc_data_i in the cycle adc_done_i is high. Lane c occupies adc_data_i[12c+11:12c].
- R7: Each FIFO word is {slot[19:14], connector[13:12], sample[11:0]}. Slots run in ascending order from 0 to N_MCLK-1. Within a slot, N_CHIP words are written for connectors 0,1,2,3 in that order, and the sample of connector k comes from chip cfg_map_i[2k+1:2k].
- R8: After the last word of the final slot, hold_no_o returns to 1 and done_o is high for one cycle, both changing at the same edge. Exactly N_MCLK*N_CHIP (152) words are written per readout.
- R9: A trigger rising edge while a readout is in progress is ignored. It starts nothing, and miss_cnt_o is incremented by one, saturating at its maximum.
- R10: cfg_load_i latches delay, calibration enable and map only while idle. A load during a readout has no effect on the current or later readouts. A load never writes the FIFO and never lowers hold_no_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Trigger; its rising edge starts a readout |
| cfg_load_i | input | 1 | Configuration load strobe |
| cfg_hold_dly_i | input | DLY_W (8) | Hold delay in cycles |
| cfg_cal_en_i | input | 1 | Calibration strobe enable |
| cfg_map_i | input | N_CHIP*CONN_W (8) | Chip index feeding each connector |
| hold_no_o | output | 1 | Active-low hold to the front-end chips |
| cal_o | output | 1 | Calibration strobe |
| mux_clk_o | output | 1 | Multiplex clock |
| srin_o | output | 1 | Shift-register start token |
| adc_start_o | output | 1 | Conversion request to all lanes |
| adc_done_i | input | 1 | Conversion complete, lane data valid |
| adc_data_i | input | N_CHIP*ADC_W (48) | Lane samples, lane c at bits 12c+11:12c |
| fifo_wr_o | output | 1 | FIFO write enable |
| fifo_data_o | output | WORD_W (20) | Tagged sample word |
| done_o | output | 1 | Readout finished pulse |
| miss_cnt_o | output | MISS_W (8) | Saturating count of ignored triggers |

## Verification
The hardest situation to reach is a trigger edge and a configuration load that both land in the middle of a burst. Neither has any visible effect at that moment, so their absence only shows later. To expose it, the stimulus fires a trigger pulse and a load of a different delay, calibration setting and map some tens of cycles into a running readout. It then checks that the miss counter moved by exactly one and that no second readout follows. The next readout must still use the old delay, leave calibration off and keep the old connector order. An ADC model with varying conversion latency makes the wait-for-done path differ from slot to slot.

// File: rtl/fe_mux_pkg.sv
package fe_mux_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DLY,
    ST_HLD,
    ST_MHI,
    ST_MLO,
    ST_CONV,
    ST_WR
  } seq_st_e;
endpackage

// File: rtl/fe_trig_ctl.sv
module fe_trig_ctl #(
  parameter int unsigned N_CHIP = 4,
  parameter int unsigned CONN_W = 2,
  parameter int unsigned DLY_W  = 8,
  parameter int unsigned MISS_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     trig_i,
  input  logic                     busy_i,
  input  logic                     cfg_load_i,
  input  logic [DLY_W-1:0]         cfg_dly_i,
  input  logic                     cfg_cal_en_i,
  input  logic [N_CHIP*CONN_W-1:0] cfg_map_i,
  output logic                     go_o,
  output logic [DLY_W-1:0]         dly_o,
  output logic                     cal_en_o,
  output logic [N_CHIP*CONN_W-1:0] map_o,
  output logic [MISS_W-1:0]        miss_cnt_o
);
  logic trig_q;
  logic trig_edge;

  assign trig_edge = trig_i & ~trig_q;
  assign go_o      = trig_edge & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= trig_i;
  end

  // config shadow, only writable between readouts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_o    <= '0;
      cal_en_o <= 1'b0;
      for (int k = 0; k < int'(N_CHIP); k++) map_o[k*CONN_W +: CONN_W] <= CONN_W'(k);
    end else if (cfg_load_i && !busy_i) begin
      dly_o    <= cfg_dly_i;
      cal_en_o <= cfg_cal_en_i;
      map_o    <= cfg_map_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) miss_cnt_o <= '0;
    else if (trig_edge && busy_i && (miss_cnt_o != '1)) miss_cnt_o <= miss_cnt_o + 1'b1;
  end
endmodule

// File: rtl/fe_seq_fsm.sv
module fe_seq_fsm
  import fe_mux_pkg::*;
#(
  parameter int unsigned N_CHIP = 4,
  parameter int unsigned N_MCLK = 38,
  parameter int unsigned DLY_W  = 8,
  parameter int unsigned SLOT_W = 6,
  parameter int unsigned CONN_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [DLY_W-1:0]  dly_i,
  input  logic              cal_en_i,
  input  logic              adc_done_i,
  output logic              busy_o,
  output logic              hold_no_o,
  output logic              cal_o,
  output logic              mux_clk_o,
  output logic              srin_o,
  output logic              adc_start_o,
  output logic              done_o,
  output logic              cap_o,
  output logic              wr_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [CONN_W-1:0] conn_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_MCLK - 1);
  localparam logic [CONN_W-1:0] LAST_CONN = CONN_W'(N_CHIP - 1);

  seq_st_e           st_q, st_d;
  logic [DLY_W-1:0]  cnt_q, cnt_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [CONN_W-1:0] conn_q, conn_d;
  logic              fin;
  logic              in_hold_d;
  logic              srin_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    slot_d = slot_q;
    conn_d = conn_q;
    fin    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (go_i) begin
        st_d  = ST_DLY;
        cnt_d = dly_i;
      end
      ST_DLY: begin
        if (cnt_q == '0) st_d = ST_HLD;
        else             cnt_d = cnt_q - 1'b1;
      end
      ST_HLD: begin
        st_d   = ST_MHI;
        slot_d = '0;
      end
      ST_MHI: st_d = ST_MLO;
      ST_MLO: st_d = ST_CONV;
      ST_CONV: if (adc_done_i) begin
        st_d   = ST_WR;
        conn_d = '0;
      end
      ST_WR: begin
        if (conn_q == LAST_CONN) begin
          if (slot_q == LAST_SLOT) begin
            st_d = ST_IDLE;
            fin  = 1'b1;
          end else begin
            st_d   = ST_MHI;
            slot_d = slot_q + 1'b1;
          end
        end else begin
          conn_d = conn_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign in_hold_d = st_d inside {ST_HLD, ST_MHI, ST_MLO, ST_CONV, ST_WR};
  // token present from just after first rise through the second rise
  assign srin_d = ((slot_d == '0) && (st_d inside {ST_MLO, ST_CONV, ST_WR})) ||
                  ((slot_d == SLOT_W'(1)) && (st_d == ST_MHI));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      slot_q <= '0;
      conn_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
      conn_q <= conn_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_no_o   <= 1'b1;
      cal_o       <= 1'b0;
      mux_clk_o   <= 1'b0;
      srin_o      <= 1'b0;
      adc_start_o <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      hold_no_o   <= ~in_hold_d;
      cal_o       <= (st_d == ST_HLD) && cal_en_i;
      mux_clk_o   <= (st_d == ST_MHI);
      srin_o      <= srin_d;
      adc_start_o <= (st_d == ST_CONV) && (st_q == ST_MLO);
      done_o      <= fin;
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign cap_o  = (st_q == ST_CONV) && adc_done_i;
  assign wr_o   = (st_q == ST_WR);
  assign slot_o = slot_q;
  assign conn_o = conn_q;
endmodule

// File: rtl/fe_lane_order.sv
module fe_lane_order #(
  parameter int unsigned N_CHIP = 4,
  parameter int unsigned ADC_W  = 12,
  parameter int unsigned SLOT_W = 6,
  parameter int unsigned CONN_W = 2,
  localparam int unsigned WORD_W = SLOT_W + CONN_W + ADC_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cap_i,
  input  logic [N_CHIP*ADC_W-1:0]  adc_data_i,
  input  logic [N_CHIP*CONN_W-1:0] map_i,
  input  logic                     wr_i,
  input  logic [SLOT_W-1:0]        slot_i,
  input  logic [CONN_W-1:0]        conn_i,
  output logic                     fifo_wr_o,
  output logic [WORD_W-1:0]        fifo_data_o
);
  logic [ADC_W-1:0]  lane_q [N_CHIP];
  logic [CONN_W-1:0] map_a  [N_CHIP];
  logic [CONN_W-1:0] sel;

  for (genvar c = 0; c < int'(N_CHIP); c++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    lane_q[c] <= '0;
      else if (cap_i) lane_q[c] <= adc_data_i[c*ADC_W +: ADC_W];
    end
    assign map_a[c] = map_i[c*CONN_W +: CONN_W];
  end

  assign sel         = map_a[conn_i];
  assign fifo_wr_o   = wr_i;
  assign fifo_data_o = {slot_i, conn_i, lane_q[sel]};
endmodule

// File: rtl/fe_mux_readout.sv
module fe_mux_readout #(
  parameter int unsigned N_CHIP = 4,
  parameter int unsigned ADC_W  = 12,
  parameter int unsigned N_MCLK = 38,
  parameter int unsigned DLY_W  = 8,
  parameter int unsigned MISS_W = 8,
  localparam int unsigned SLOT_W = $clog2(N_MCLK),
  localparam int unsigned CONN_W = $clog2(N_CHIP),
  localparam int unsigned WORD_W = SLOT_W + CONN_W + ADC_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     trig_i,
  input  logic                     cfg_load_i,
  input  logic [DLY_W-1:0]         cfg_hold_dly_i,
  input  logic                     cfg_cal_en_i,
  input  logic [N_CHIP*CONN_W-1:0] cfg_map_i,
  output logic                     hold_no_o,
  output logic                     cal_o,
  output logic                     mux_clk_o,
  output logic                     srin_o,
  output logic                     adc_start_o,
  input  logic                     adc_done_i,
  input  logic [N_CHIP*ADC_W-1:0]  adc_data_i,
  output logic                     fifo_wr_o,
  output logic [WORD_W-1:0]        fifo_data_o,
  output logic                     done_o,
  output logic [MISS_W-1:0]        miss_cnt_o
);
  logic                     busy, go, cal_en, cap, wr;
  logic [DLY_W-1:0]         dly;
  logic [N_CHIP*CONN_W-1:0] map;
  logic [SLOT_W-1:0]        slot;
  logic [CONN_W-1:0]        conn;

  fe_trig_ctl #(
    .N_CHIP(N_CHIP), .CONN_W(CONN_W), .DLY_W(DLY_W), .MISS_W(MISS_W)
  ) u_trig (
    .clk_i, .rst_ni, .trig_i,
    .busy_i      (busy),
    .cfg_load_i,
    .cfg_dly_i   (cfg_hold_dly_i),
    .cfg_cal_en_i,
    .cfg_map_i,
    .go_o        (go),
    .dly_o       (dly),
    .cal_en_o    (cal_en),
    .map_o       (map),
    .miss_cnt_o
  );

  fe_seq_fsm #(
    .N_CHIP(N_CHIP), .N_MCLK(N_MCLK), .DLY_W(DLY_W), .SLOT_W(SLOT_W), .CONN_W(CONN_W)
  ) u_seq (
    .clk_i, .rst_ni,
    .go_i       (go),
    .dly_i      (dly),
    .cal_en_i   (cal_en),
    .adc_done_i,
    .busy_o     (busy),
    .hold_no_o, .cal_o, .mux_clk_o, .srin_o, .adc_start_o, .done_o,
    .cap_o      (cap),
    .wr_o       (wr),
    .slot_o     (slot),
    .conn_o     (conn)
  );

  fe_lane_order #(
    .N_CHIP(N_CHIP), .ADC_W(ADC_W), .SLOT_W(SLOT_W), .CONN_W(CONN_W)
  ) u_order (
    .clk_i, .rst_ni,
    .cap_i   (cap),
    .adc_data_i,
    .map_i   (map),
    .wr_i    (wr),
    .slot_i  (slot),
    .conn_i  (conn),
    .fifo_wr_o,
    .fifo_data_o
  );
endmodule

// File: rtl/fe_mux_readout_chk.sv
module fe_mux_readout_chk #(
  parameter int unsigned MISS_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hold_no_o,
  input logic              cal_o,
  input logic              mux_clk_o,
  input logic              srin_o,
  input logic              adc_start_o,
  input logic              fifo_wr_o,
  input logic              done_o,
  input logic [MISS_W-1:0] miss_cnt_o
);
  assert_cal_on_hold_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_o |-> $fell(hold_no_o));

  assert_mux_in_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mux_clk_o |-> !hold_no_o);

  assert_mux_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mux_clk_o |=> !mux_clk_o);

  assert_srin_in_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srin_o |-> !hold_no_o);

  assert_start_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> !adc_start_o);

  assert_start_apart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> !mux_clk_o && !hold_no_o);

  assert_done_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(hold_no_o));

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_miss_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_cnt_o != $past(miss_cnt_o)) |-> (miss_cnt_o == $past(miss_cnt_o) + 1'b1));

  assert_wr_in_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> !hold_no_o);
endmodule

bind fe_mux_readout fe_mux_readout_chk #(.MISS_W(MISS_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hold_no_o   (hold_no_o),
  .cal_o       (cal_o),
  .mux_clk_o   (mux_clk_o),
  .srin_o      (srin_o),
  .adc_start_o (adc_start_o),
  .fifo_wr_o   (fifo_wr_o),
  .done_o      (done_o),
  .miss_cnt_o  (miss_cnt_o)
);

// File: tb/fe_mux_readout_tb_top.sv
module fe_mux_readout_tb_top;
  localparam int N_CHIP = 4;
  localparam int ADC_W  = 12;
  localparam int N_MCLK = 38;
  localparam int WORDS  = N_MCLK * N_CHIP;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        trig_i = 1'b0;
  logic        cfg_load_i = 1'b0;
  logic [7:0]  cfg_hold_dly_i = '0;
  logic        cfg_cal_en_i = 1'b0;
  logic [7:0]  cfg_map_i = '0;
  logic        adc_done_i = 1'b0;
  logic [47:0] adc_data_i = '0;
  logic        hold_no_o, cal_o, mux_clk_o, srin_o, adc_start_o, fifo_wr_o, done_o;
  logic [19:0] fifo_data_o;
  logic [7:0]  miss_cnt_o;

  fe_mux_readout dut_i (.*);

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  int bno = 0;
  int exp_cal = 0;
  int cur_map [N_CHIP];
  int wr_total = 0;
  logic [19:0] exp_q [$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] samp(input int b, input int s, input int c);
    logic [3:0] bb; logic [5:0] ss; logic [1:0] cc;
    bb = b[3:0]; ss = s[5:0]; cc = c[1:0];
    return {bb, ss, cc};
  endfunction

  // ADC model with varying latency
  int lat = 0, starts = 0, cur_slot = 0;
  always @(negedge clk_i) begin
    adc_done_i = 1'b0;
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        adc_done_i = 1'b1;
        for (int c = 0; c < N_CHIP; c++) adc_data_i[c*ADC_W +: ADC_W] = samp(bno, cur_slot, c);
      end
    end
    if (adc_start_o) begin
      cur_slot = starts;
      starts++;
      lat = 1 + (starts % 3);
    end
    if (done_o) starts = 0;
  end

  // scoreboard monitor and burst statistics
  int rises = 0, nstart = 0, ncal = 0, nwr = 0;
  logic p_mux = 1'b0, p_srin = 1'b0, p_hold = 1'b1, p_done = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (fifo_wr_o) begin
        wr_total++; nwr++;
        if (exp_q.size() == 0) chk(1'b0, "R7 unexpected write", fifo_data_o, 0);
        else begin
          logic [19:0] e;
          e = exp_q.pop_front();
          chk(fifo_data_o == e, "R7 word", fifo_data_o, e);
        end
      end
      if (mux_clk_o && !p_mux) begin
        rises++;
        if (rises == 2) chk(srin_o && p_srin, "R5 token at second rise", {p_srin, srin_o}, 3);
        else            chk(!srin_o, "R5 token absent", srin_o, 0);
      end
      if (adc_start_o) begin
        nstart++;
        chk(!mux_clk_o, "R6 start apart from clock", mux_clk_o, 0);
      end
      if (cal_o) begin
        ncal++;
        chk(p_hold && !hold_no_o, "R3 cal on first hold cycle", {p_hold, hold_no_o}, 2);
      end
      if (done_o && p_done) chk(1'b0, "R8 done width", 2, 1);
      if (done_o) begin
        chk(hold_no_o && !p_hold, "R8 hold release with done", {p_hold, hold_no_o}, 1);
        chk(nwr == WORDS, "R8 word count", nwr, WORDS);
        chk(rises == N_MCLK, "R4 clock count", rises, N_MCLK);
        chk(nstart == N_MCLK, "R6 start count", nstart, N_MCLK);
        chk(ncal == exp_cal, "R3 cal count", ncal, exp_cal);
        rises = 0; nstart = 0; ncal = 0; nwr = 0;
      end
      p_mux = mux_clk_o; p_srin = srin_o; p_hold = hold_no_o; p_done = done_o;
    end
  end

  int cyc = 0;
  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic load_cfg(input int d, input bit cal, input int m [N_CHIP]);
    cfg_hold_dly_i = d[7:0];
    cfg_cal_en_i   = cal;
    for (int k = 0; k < N_CHIP; k++) cfg_map_i[2*k +: 2] = m[k][1:0];
    cfg_load_i = 1'b1;
    @(negedge clk_i);
    cfg_load_i = 1'b0;
  endtask

  task automatic quiet_check(input int n, input string tag);
    int w0;
    w0 = wr_total;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (!hold_no_o) begin chk(1'b0, tag, 0, 1); return; end
    end
    chk(wr_total == w0, tag, wr_total - w0, 0);
  endtask

  task automatic run_burst(input int d, input bit cal, input bit disturb);
    int cnt;
    int m [N_CHIP];
    bno++;
    exp_cal = cal ? 1 : 0;
    for (int s = 0; s < N_MCLK; s++)
      for (int k = 0; k < N_CHIP; k++) begin
        logic [5:0] ss; logic [1:0] kk;
        ss = s[5:0]; kk = k[1:0];
        exp_q.push_back({ss, kk, samp(bno, s, cur_map[k])});
      end
    trig_i = 1'b1;
    cnt = 0;
    do begin
      @(negedge clk_i);
      cnt++;
    end while (hold_no_o && cnt < 1000);
    chk(cnt == d + 2, "R2 hold latency", cnt, d + 2);
    repeat (2) @(negedge clk_i);
    trig_i = 1'b0;
    if (disturb) begin
      repeat (30) @(negedge clk_i);
      trig_i = 1'b1;
      @(negedge clk_i);
      trig_i = 1'b0;
      for (int k = 0; k < N_CHIP; k++) m[k] = N_CHIP - 1 - k;
      load_cfg(20, 1'b1, m);
    end
    while (!done_o) @(negedge clk_i);
    @(negedge clk_i);
    chk(exp_q.size() == 0, "R7 all words seen", exp_q.size(), 0);
    quiet_check(30, "R2 single readout per trigger");
  endtask

  initial begin
    int m_a [N_CHIP];
    int m_id [N_CHIP];
    int m_rev [N_CHIP];
    int m0;
    m_a = '{2, 0, 3, 1};
    for (int k = 0; k < N_CHIP; k++) begin
      m_id[k] = k; m_rev[k] = N_CHIP - 1 - k; cur_map[k] = k;
    end

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(hold_no_o == 1'b1, "R1 hold idle", hold_no_o, 1);
    chk({mux_clk_o, srin_o, cal_o, adc_start_o, fifo_wr_o, done_o} == '0, "R1 strobes low",
        {mux_clk_o, srin_o, cal_o, adc_start_o, fifo_wr_o, done_o}, 0);
    chk(miss_cnt_o == 0, "R1 miss count", miss_cnt_o, 0);

    // reset defaults: delay 0, cal off, identity map
    run_burst(0, 1'b0, 1'b0);

    // R10 idle load writes nothing
    load_cfg(3, 1'b1, m_a);
    cur_map = m_a;
    quiet_check(10, "R10 idle load side effects");
    run_burst(3, 1'b1, 1'b0);

    load_cfg(7, 1'b0, m_id);
    cur_map = m_id;
    // R9 and R10: trigger and load during a readout
    m0 = miss_cnt_o;
    run_burst(7, 1'b0, 1'b1);
    chk(miss_cnt_o == m0 + 1, "R9 missed trigger counted", miss_cnt_o, m0 + 1);
    // busy-time load must not have taken effect
    run_burst(7, 1'b0, 1'b0);

    load_cfg(2, 1'b1, m_rev);
    cur_map = m_rev;
    run_burst(2, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule